// File: doc/BRIEF.md
# Instruction predicate evaluation unit

This block decides, for every instruction of a parallel issue packet, whether that instruction is allowed to take effect. Each slot presents a 32-bit instruction word and a valid bit. The top nibble of the word is a condition field. It holds a 3-bit selector that names one of five predicate-capable registers, and a sense bit. When the sense bit is 1 the instruction executes only if the selected register is zero. When it is 0 the instruction executes only if the register is nonzero. One selector code means "always execute". The remaining codes are reserved.

The register values are sampled in the same cycle as the packet, which is the start of the first execute stage. A value that reaches the register port by that cycle is the value that counts. On the next clock edge, each slot's execute-enable and reserved-encoding flags are registered into the execute stage. The packet stream has no back-pressure. A new packet is accepted on every clock, and a slot whose valid bit is low is treated as a bubble. Every slot evaluates its own condition independently, so two slots that test the same register with opposite senses always give exactly one enable.

Top module: `pred_eval_unit`

## Requirements
- R1: A valid slot whose condition nibble (word bits 31..28) is 0000 gives execute enable 1 and reserved flag 0.
- R2: With sense bit 28 = 0 and a register selector (bits 31..29) of 1 to 5, a valid slot is enabled exactly when the selected register is nonzero.
- R3: With sense bit 28 = 1 and a register selector of 1 to 5, a valid slot is enabled exactly when the selected register is zero.
- R4: Selector code k (1 to 5) reads register word k-1, which sits at bits [32(k-1)+31 : 32(k-1)] of `cond_regs`.
- R5: Condition nibble 0001 (selector 0, sense 1) on a valid slot gives reserved flag 1 and execute enable 0.
- R6: Selectors 110 and 111 on a valid slot give reserved flag 1 and execute enable 0, whatever the sense bit.
- R7: A slot with valid low gives execute enable 0 and reserved flag 0, whatever its opcode bits.
- R8: The outputs for the inputs sampled at a clock edge appear after that edge and hold for one cycle. The register values used are the ones present in that same cycle.
- R9: While the synchronous active-high reset is sampled high, all enables and reserved flags go to 0 at the next edge.
- R10: Slots are independent. Two valid slots that test the same register with opposite senses yield exactly one enabled slot.
- R11: A register counts as zero only when all 32 bits are 0. Any single set bit, including bit 31, makes it nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | NSLOT | Per-slot valid bit for the current packet |
| slot_insn | input | NSLOT*32 | Instruction words; slot s at bits [32s+31:32s] |
| cond_regs | input | 5*32 | Predicate registers as of the first execute stage; word k-1 answers selector k |
| exec_en | output | NSLOT | Registered per-slot execute enable |
| rsvd_flag | output | NSLOT | Registered per-slot reserved-encoding flag |

## Verification
The properties assume that every input is a settled, known value at each rising edge. They also assume that the register values on `cond_regs` already belong to the packet that is present in the same cycle. The bench meets both assumptions by changing the packet, the valid bits, the register values and the reset only together on the falling edge. The properties also assume that reset is asserted from time zero. The bench holds reset high for its first cycles before it drives any packet.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int SEL_W    = 3;
  localparam int COND_W   = SEL_W + 1;
  localparam int NUM_CREG = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_ALWAYS = 3'd0,
    SEL_REG0   = 3'd1,
    SEL_REG1   = 3'd2,
    SEL_REG2   = 3'd3,
    SEL_REG3   = 3'd4,
    SEL_REG4   = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } cond_sel_e;

  typedef struct packed {
    cond_sel_e sel;
    logic      want_zero;
  } cond_field_t;
endpackage

// File: rtl/pred_zero_detect.sv
module pred_zero_detect #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  output logic              is_zero
);
  assign is_zero = ~|word;
endmodule

// File: rtl/pred_slot_eval.sv
module pred_slot_eval
  import pred_pkg::*;
#(
  parameter int NCREG = pred_pkg::NUM_CREG
) (
  input  logic             valid,
  input  cond_field_t      cond,
  input  logic [NCREG-1:0] reg_zero,
  output logic             en,
  output logic             rsvd
);
  localparam int SEL_SPAN = 1 << SEL_W;

  logic [SEL_SPAN-1:0] zero_pad;
  logic [SEL_W-1:0]    reg_idx;

  assign zero_pad = {{(SEL_SPAN-NCREG){1'b0}}, reg_zero};
  assign reg_idx  = cond.sel - 3'd1;

  always_comb begin
    en   = 1'b0;
    rsvd = 1'b0;
    if (valid) begin
      case (cond.sel)
        SEL_ALWAYS: begin
          if (cond.want_zero) rsvd = 1'b1;
          else                en   = 1'b1;
        end
        SEL_RSV6, SEL_RSV7: rsvd = 1'b1;
        default: en = cond.want_zero ? zero_pad[reg_idx] : ~zero_pad[reg_idx];
      endcase
    end
  end
endmodule

// File: rtl/pred_eval_unit.sv
module pred_eval_unit
  import pred_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int WORD_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSLOT-1:0]           slot_valid,
  input  logic [NSLOT*WORD_W-1:0]    slot_insn,
  input  logic [NUM_CREG*WORD_W-1:0] cond_regs,
  output logic [NSLOT-1:0]           exec_en,
  output logic [NSLOT-1:0]           rsvd_flag
);
  localparam int COND_LSB = WORD_W - COND_W;

  logic [NUM_CREG-1:0] reg_zero;
  logic [NSLOT-1:0]    en_d;
  logic [NSLOT-1:0]    rsvd_d;

  for (genvar k = 0; k < NUM_CREG; k++) begin : g_zdet
    pred_zero_detect #(.WORD_W(WORD_W)) u_zd (
      .word    (cond_regs[k*WORD_W +: WORD_W]),
      .is_zero (reg_zero[k])
    );
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    cond_field_t cf;
    assign cf = cond_field_t'(slot_insn[s*WORD_W + COND_LSB +: COND_W]);
    pred_slot_eval #(.NCREG(NUM_CREG)) u_eval (
      .valid    (slot_valid[s]),
      .cond     (cf),
      .reg_zero (reg_zero),
      .en       (en_d[s]),
      .rsvd     (rsvd_d[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_en   <= '0;
      rsvd_flag <= '0;
    end else begin
      exec_en   <= en_d;
      rsvd_flag <= rsvd_d;
    end
  end
endmodule

// File: rtl/pred_eval_chk.sv
module pred_eval_chk #(
  parameter int NSLOT  = 4,
  parameter int WORD_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NSLOT-1:0]        slot_valid,
  input logic [NSLOT*WORD_W-1:0] slot_insn,
  input logic [NSLOT-1:0]        exec_en,
  input logic [NSLOT-1:0]        rsvd_flag
);
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (exec_en == '0 && rsvd_flag == '0));

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    p_rsvd_blocks_en_r5: assert property (@(posedge clk) disable iff (rst)
      rsvd_flag[s] |-> !exec_en[s]);

    p_bubble_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !slot_valid[s] |=> (!exec_en[s] && !rsvd_flag[s]));

    p_always_runs_r1: assert property (@(posedge clk) disable iff (rst)
      (slot_valid[s] && slot_insn[s*WORD_W + WORD_W-4 +: 4] == 4'b0000)
        |=> (exec_en[s] && !rsvd_flag[s]));

    p_high_sel_rsvd_r6: assert property (@(posedge clk) disable iff (rst)
      (slot_valid[s] && slot_insn[s*WORD_W + WORD_W-2 +: 2] == 2'b11)
        |=> rsvd_flag[s]);
  end
endmodule

bind pred_eval_unit pred_eval_chk #(.NSLOT(NSLOT), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot_valid (slot_valid),
  .slot_insn  (slot_insn),
  .exec_en    (exec_en),
  .rsvd_flag  (rsvd_flag)
);

// File: tb/sim_pred_eval_unit.sv
`timescale 1ns/1ps
module sim_pred_eval_unit;
  localparam int NS = 4;
  localparam int W  = 32;
  localparam int NR = 5;

  typedef struct {
    logic [NS-1:0] en;
    logic [NS-1:0] rsvd;
    int            due;
    string         req;
  } item_t;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NS-1:0]      slot_valid = '0;
  logic [NS*W-1:0]    slot_insn = '0;
  logic [NR*W-1:0]    cond_regs = '0;
  logic [NS-1:0]      exec_en;
  logic [NS-1:0]      rsvd_flag;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  pred_eval_unit #(.NSLOT(NS), .WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_insn(slot_insn),
    .cond_regs(cond_regs), .exec_en(exec_en), .rsvd_flag(rsvd_flag)
  );

  function automatic logic [W-1:0] mk(input int sel, input bit z, input int lo);
    return {sel[2:0], z, lo[27:0]};
  endfunction

  task automatic apply(input logic [NS-1:0] v, input logic [NS*W-1:0] ins,
                       input logic [NR*W-1:0] regs, input logic r, input string req);
    item_t it;
    @(negedge clk);
    rst = r; slot_valid = v; slot_insn = ins; cond_regs = regs;
    it.en = '0; it.rsvd = '0; it.due = cyc + 1; it.req = req;
    for (int s = 0; s < NS; s++) begin
      logic [W-1:0] w;
      int sel;
      w = ins[s*W +: W];
      sel = int'(w[31:29]);
      if (v[s] && !r) begin
        if (sel == 0) begin
          if (w[28]) it.rsvd[s] = 1'b1; else it.en[s] = 1'b1;
        end else if (sel >= 6) it.rsvd[s] = 1'b1;
        else begin
          logic [W-1:0] rv;
          rv = regs[(sel-1)*W +: W];
          it.en[s] = w[28] ? (rv == '0) : (rv != '0);
        end
      end
    end
    q.push_back(it);
  endtask

  always begin
    @(posedge clk);
    #1;
    cyc++;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (exec_en !== it.en || rsvd_flag !== it.rsvd) begin
        n_bad++;
        $display("FAIL %s: got en=%b rsvd=%b expected en=%b rsvd=%b",
                 it.req, exec_en, rsvd_flag, it.en, it.rsvd);
      end
    end
  end

  initial begin
    logic [NR*W-1:0] regs;
    logic [NS*W-1:0] ins;
    apply('1, {NS{mk(0, 0, 5)}}, '0, 1'b1, "R9 reset state");
    apply('1, {NS{mk(0, 0, 7)}}, '0, 1'b1, "R9 reset state");
    apply('1, {mk(0,0,1), mk(0,0,2), mk(0,0,3), mk(0,0,4)}, '0, 1'b0, "R1 unconditional");
    for (int k = 1; k <= 5; k++) begin
      regs = '0;
      regs[(k-1)*W +: W] = 32'h0000_0100 << k;
      apply('1, {mk(k,0,9), mk(k,1,9), mk(k%5+1,0,9), mk(k%5+1,1,9)}, regs, 1'b0,
            "R2/R3/R4 selector mapping");
      regs = ~regs;
      apply('1, {mk(k,0,3), mk(k,1,3), mk(k%5+1,0,3), mk(k%5+1,1,3)}, regs, 1'b0,
            "R2/R3/R4 selector inverted");
    end
    apply('1, {mk(0,1,0), mk(6,0,0), mk(6,1,0), mk(7,0,0)}, '1, 1'b0, "R5/R6 reserved codes");
    apply('1, {mk(7,1,0), mk(0,1,8), mk(1,0,0), mk(7,0,5)}, '1, 1'b0, "R5/R6 reserved mix");
    apply(4'b0000, {mk(0,1,0), mk(6,0,0), mk(0,0,0), mk(1,0,0)}, '1, 1'b0, "R7 all bubbles");
    apply(4'b0101, {mk(0,0,0), mk(7,1,0), mk(0,0,0), mk(0,1,0)}, '1, 1'b0, "R7 partial valid");
    regs = '0; regs[2*W +: W] = 32'h1;
    apply('1, {mk(3,0,1), mk(3,1,2), mk(3,0,3), mk(3,1,4)}, regs, 1'b0, "R10 opposite senses");
    regs[2*W +: W] = 32'h0;
    apply('1, {mk(3,0,1), mk(3,1,2), mk(3,0,3), mk(3,1,4)}, regs, 1'b0, "R10 opposite senses zero");
    regs = '0; regs[4*W +: W] = 32'h8000_0000;
    apply('1, {mk(5,0,0), mk(5,1,0), mk(4,1,0), mk(4,0,0)}, regs, 1'b0, "R11 top bit nonzero");
    for (int t = 0; t < 6; t++) begin
      regs = '0;
      regs[0 +: W] = (t % 2 == 0) ? 32'h0 : 32'h40;
      ins = {mk(1,0,t), mk(1,1,t), mk(t%2 == 0 ? 6 : 0, 0, t), mk(2,1,t)};
      apply('1, ins, regs, 1'b0, "R8 back-to-back latency");
    end
    apply('1, {NS{mk(0,1,0)}}, '1, 1'b1, "R9 mid-stream reset");
    apply('1, {NS{mk(0,0,0)}}, '1, 1'b0, "R1 after reset");
    apply('0, '0, '0, 1'b0, "R7 drain");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R8: %0d results never compared, expected 0", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule